// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command front end of a flash memory. A host writes 8-bit command codes over a single write strobe. Only the low byte of the data bus carries the code. The controller decodes each code and chooses what a read returns: the memory array, the status byte or the identifier. It also runs the two-write sequences that launch a program or a block erase, and it keeps an 8-bit status byte.

An internal countdown timer stands in for the embedded write algorithm. While that timer runs, the controller is locked. It honours only a status read and, during an erase, suspend and resume. When the timer expires, the ready bit returns to 1 and the full command set is accepted again.

The block drives a one-cycle program or erase request that carries the latched address and data. Storage, real cell timing and the pin-level interface are left to neighbouring blocks.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, readMode is 0 (array), statusByte is 80h (ready set, every other bit clear), and pgmReq, eraseReq and opDone are low.
- R2: When idle, a write of FFh sets readMode to 0 (array), 70h sets it to 1 (status) and 90h sets it to 2 (identifier). The new mode shows from the cycle after the write. Bits 15:8 of wrData never affect decoding.
- R3: A write of 40h or 10h, followed by any write, launches a program. pgmReq is high for exactly the one cycle after the second write, with reqAddr and reqData (low byte) taken from that write. From the same cycle, status bit 7 is 0 and readMode is 1.
- R4: A write of 20h followed by D0h launches an erase. eraseReq is high for one cycle with reqAddr taken from the D0h write, and status bit 7 falls as it does in R3.
- R5: A write of 20h followed by any value other than D0h sets status bits 5 and 4, returns readMode to 0 and raises no request.
- R6: Status bit 7 is 1 again exactly PGM_CYCLES cycles after the request cycle for a program, and ERASE_CYCLES cycles after it for an erase, counting time not spent suspended. opDone is high for exactly that first ready cycle.
- R7: While status bit 7 is 0, every write other than B0h and D0h during an erase leaves readMode at 1 and raises no request.
- R8: B0h during a running erase sets status bit 6 and freezes the countdown. D0h while suspended clears bit 6 and resumes the countdown from where it stopped.
- R9: 50h clears status bits 5 and 4 and leaves bits 7 and 6 and readMode unchanged.
- R10: When idle, an undefined code such as 00h, B0h or D0h leaves readMode and statusByte unchanged and raises no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one cycle per host write |
| wrAddr | input | ADDR_W | Address of the host write |
| wrData | input | 16 | Write data; the command is the low byte |
| readMode | output | 2 | 0 array, 1 status, 2 identifier |
| statusByte | output | 8 | Bit 7 ready, bit 6 erase suspended, bit 5 erase error, bit 4 program/sequence error, bits 3:0 zero |
| pgmReq | output | 1 | One-cycle program request |
| eraseReq | output | 1 | One-cycle block-erase request |
| reqAddr | output | ADDR_W | Address latched with the request |
| reqData | output | 8 | Data byte latched with the request |
| opDone | output | 1 | One-cycle pulse when the engine finishes |

## Verification
Each write is registered once. The new readMode, status bits and request pulse therefore appear in the cycle after the write. Ready returns exactly PGM_CYCLES or ERASE_CYCLES cycles after the request cycle, and that count is stretched by every cycle spent suspended.

The bench keeps a behavioural model. The model advances at each rising edge from the same inputs as the design, and the bench compares every output with the model at each falling edge. Every delay is therefore checked on its exact cycle and not inside a window. Stimulus covers writes issued on the last busy cycle and commands sent during the locked period.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_STATUS = 2'd1,
    MODE_IDENT  = 2'd2
  } readMode_e;

  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_PGM_A   = 8'h40;
  localparam logic [7:0] CMD_PGM_B   = 8'h10;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;

  localparam int BIT_READY   = 7;
  localparam int BIT_SUSPEND = 6;
  localparam int BIT_ERS_ERR = 5;
  localparam int BIT_PGM_ERR = 4;

  typedef struct packed {
    logic startPgm;
    logic startErase;
    logic setSeqErr;
    logic clrErr;
    logic setSusp;
    logic clrSusp;
  } ctrlStrobe_t;

endpackage

// File: rtl/fcc_ctrl.sv
module fcc_ctrl
  import fcc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [7:0]  cmd,
  input  logic        engDone,
  output ctrlStrobe_t strobe,
  output readMode_e   mode
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PGM_SETUP,
    ST_ERASE_SETUP,
    ST_BUSY_PGM,
    ST_BUSY_ERASE,
    ST_SUSPENDED
  } ctrlState_e;

  ctrlState_e state, stateNext;
  readMode_e  modeNext;

  always_comb begin
    stateNext = state;
    modeNext  = mode;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (wrEn) begin
          unique case (cmd)
            CMD_ARRAY:  modeNext = MODE_ARRAY;
            CMD_STATUS: modeNext = MODE_STATUS;
            CMD_IDENT:  modeNext = MODE_IDENT;
            CMD_CLEAR:  strobe.clrErr = 1'b1;
            CMD_PGM_A,
            CMD_PGM_B:  stateNext = ST_PGM_SETUP;
            CMD_ERASE:  stateNext = ST_ERASE_SETUP;
            default: ;
          endcase
        end
      end
      ST_PGM_SETUP: begin
        if (wrEn) begin
          strobe.startPgm = 1'b1;
          modeNext        = MODE_STATUS;
          stateNext       = ST_BUSY_PGM;
        end
      end
      ST_ERASE_SETUP: begin
        if (wrEn) begin
          if (cmd == CMD_CONFIRM) begin
            strobe.startErase = 1'b1;
            modeNext          = MODE_STATUS;
            stateNext         = ST_BUSY_ERASE;
          end else begin
            strobe.setSeqErr = 1'b1;
            modeNext         = MODE_ARRAY;
            stateNext        = ST_IDLE;
          end
        end
      end
      ST_BUSY_PGM: begin
        if (engDone) stateNext = ST_IDLE;
      end
      ST_BUSY_ERASE: begin
        if (engDone) begin
          stateNext = ST_IDLE;
        end else if (wrEn && cmd == CMD_SUSPEND) begin
          strobe.setSusp = 1'b1;
          stateNext      = ST_SUSPENDED;
        end
      end
      ST_SUSPENDED: begin
        if (wrEn && cmd == CMD_CONFIRM) begin
          strobe.clrSusp = 1'b1;
          stateNext      = ST_BUSY_ERASE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      mode  <= MODE_ARRAY;
    end else begin
      state <= stateNext;
      mode  <= modeNext;
    end
  end

endmodule

// File: rtl/fcc_datapath.sv
module fcc_datapath
  import fcc_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int PGM_CYCLES   = 6,
  parameter int ERASE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrByte,
  output logic              engDone,
  output logic [7:0]        statusByte,
  output logic              pgmReq,
  output logic              eraseReq,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [7:0]        reqData,
  output logic              opDone
);

  localparam int MAX_CYCLES = (PGM_CYCLES > ERASE_CYCLES) ? PGM_CYCLES : ERASE_CYCLES;
  localparam int CNT_W      = $clog2(MAX_CYCLES + 1);
  localparam logic [CNT_W-1:0] PGM_LOAD   = CNT_W'(PGM_CYCLES);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES);

  logic [CNT_W-1:0] remain;
  logic             running;
  logic             ready, suspended, ersErr, pgmErr;

  assign engDone    = running && !suspended && (remain == CNT_W'(1));
  assign statusByte = {ready, suspended, ersErr, pgmErr, 4'b0000};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain    <= '0;
      running   <= 1'b0;
      ready     <= 1'b1;
      suspended <= 1'b0;
      ersErr    <= 1'b0;
      pgmErr    <= 1'b0;
      pgmReq    <= 1'b0;
      eraseReq  <= 1'b0;
      opDone    <= 1'b0;
      reqAddr   <= '0;
      reqData   <= '0;
    end else begin
      pgmReq   <= strobe.startPgm;
      eraseReq <= strobe.startErase;
      opDone   <= engDone;
      if (strobe.startPgm || strobe.startErase) begin
        reqAddr <= wrAddr;
        reqData <= wrByte;
        running <= 1'b1;
        ready   <= 1'b0;
        remain  <= strobe.startPgm ? PGM_LOAD : ERASE_LOAD;
      end else if (engDone) begin
        running <= 1'b0;
        ready   <= 1'b1;
        remain  <= '0;
      end else if (running && !suspended) begin
        remain <= remain - CNT_W'(1);
      end
      if (strobe.setSusp) suspended <= 1'b1;
      else if (strobe.clrSusp) suspended <= 1'b0;
      if (strobe.clrErr) begin
        ersErr <= 1'b0;
        pgmErr <= 1'b0;
      end else if (strobe.setSeqErr) begin
        ersErr <= 1'b1;
        pgmErr <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int PGM_CYCLES   = 6,
  parameter int ERASE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [15:0]       wrData,
  output logic [1:0]        readMode,
  output logic [7:0]        statusByte,
  output logic              pgmReq,
  output logic              eraseReq,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [7:0]        reqData,
  output logic              opDone
);

  ctrlStrobe_t strobe;
  readMode_e   mode;
  logic        engDone;

  fcc_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .cmd     (wrData[7:0]),
    .engDone (engDone),
    .strobe  (strobe),
    .mode    (mode)
  );

  fcc_datapath #(
    .ADDR_W       (ADDR_W),
    .PGM_CYCLES   (PGM_CYCLES),
    .ERASE_CYCLES (ERASE_CYCLES)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrAddr     (wrAddr),
    .wrByte     (wrData[7:0]),
    .engDone    (engDone),
    .statusByte (statusByte),
    .pgmReq     (pgmReq),
    .eraseReq   (eraseReq),
    .reqAddr    (reqAddr),
    .reqData    (reqData),
    .opDone     (opDone)
  );

  assign readMode = mode;

endmodule

// File: rtl/fcc_checker.sv
module fcc_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] readMode,
  input logic [7:0] statusByte,
  input logic       pgmReq,
  input logic       eraseReq,
  input logic       opDone
);

  assert_req_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pgmReq, eraseReq}));

  assert_pgm_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    pgmReq |=> !pgmReq);

  assert_req_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pgmReq || eraseReq) |-> (!statusByte[7] && readMode == 2'd1));

  assert_done_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    opDone |-> (statusByte[7] && !$past(statusByte[7])));

  assert_locked_status_R7: assert property (@(posedge clk) disable iff (!rstN)
    !statusByte[7] |-> readMode == 2'd1);

  assert_suspend_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[6] |-> !statusByte[7]);

  assert_seq_err_array_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusByte[5]) |-> (readMode == 2'd0 && statusByte[4]));

  assert_low_nibble_R1: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[3:0] == 4'h0);

endmodule

bind flash_cmd_ctrl fcc_checker chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .readMode   (readMode),
  .statusByte (statusByte),
  .pgmReq     (pgmReq),
  .eraseReq   (eraseReq),
  .opDone     (opDone)
);

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb_top;

  localparam int AW = 17;
  localparam int PGM_N = 6;
  localparam int ERS_N = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [15:0]   wrData = '0;
  logic [1:0]    readMode;
  logic [7:0]    statusByte;
  logic          pgmReq, eraseReq, opDone;
  logic [AW-1:0] reqAddr;
  logic [7:0]    reqData;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(AW), .PGM_CYCLES(PGM_N), .ERASE_CYCLES(ERS_N)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .readMode(readMode), .statusByte(statusByte), .pgmReq(pgmReq),
    .eraseReq(eraseReq), .reqAddr(reqAddr), .reqData(reqData), .opDone(opDone)
  );

  int tests = 0;
  int fails = 0;
  string curReq = "R1";
  bit done = 1'b0;

  // Behavioural model: phase 0 idle, 1 program setup, 2 erase setup,
  // 3 program running, 4 erase running, 5 erase suspended
  int phase = 0;
  int left = 0;
  int mMode = 0;
  bit mReady = 1, mSusp = 0, mErsErr = 0, mPgmErr = 0;
  bit mPgm = 0, mErs = 0, mDone = 0;
  int mAddr = 0, mData = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      phase = 0; left = 0; mMode = 0;
      mReady = 1; mSusp = 0; mErsErr = 0; mPgmErr = 0;
      mPgm = 0; mErs = 0; mDone = 0;
    end else begin
      int c;
      c = wrData[7:0];
      mPgm = 0; mErs = 0; mDone = 0;
      case (phase)
        0: if (wrEn) begin
          if (c == 'hFF) mMode = 0;
          else if (c == 'h70) mMode = 1;
          else if (c == 'h90) mMode = 2;
          else if (c == 'h50) begin mErsErr = 0; mPgmErr = 0; end
          else if (c == 'h40 || c == 'h10) phase = 1;
          else if (c == 'h20) phase = 2;
        end
        1: if (wrEn) begin
          mPgm = 1; mAddr = wrAddr; mData = c; mReady = 0;
          mMode = 1; left = PGM_N; phase = 3;
        end
        2: if (wrEn) begin
          if (c == 'hD0) begin
            mErs = 1; mAddr = wrAddr; mData = c; mReady = 0;
            mMode = 1; left = ERS_N; phase = 4;
          end else begin
            mErsErr = 1; mPgmErr = 1; mMode = 0; phase = 0;
          end
        end
        3, 4: begin
          if (left == 1) begin
            mReady = 1; mDone = 1; phase = 0;
          end else begin
            left = left - 1;
            if (phase == 4 && wrEn && c == 'hB0) begin mSusp = 1; phase = 5; end
          end
        end
        5: if (wrEn && c == 'hD0) begin mSusp = 0; phase = 4; end
        default: ;
      endcase
    end
  end

  task automatic check(input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", curReq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      check("readMode", readMode, mMode);
      check("statusByte", statusByte, {mReady, mSusp, mErsErr, mPgmErr, 4'b0000});
      check("pgmReq", pgmReq, mPgm);
      check("eraseReq", eraseReq, mErs);
      check("opDone", opDone, mDone);
      if (mPgm || mErs) begin
        check("reqAddr", reqAddr, mAddr);
        check("reqData", reqData, mData);
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = AW'(a); wrData = 16'(d);
    @(negedge clk);
    wrEn = 1'b0; wrData = 16'h0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curReq = "R1";
    @(negedge clk);
    tests++;
    if (readMode != 2'd0 || statusByte != 8'h80 || pgmReq || eraseReq || opDone) begin
      fails++;
      $display("FAIL R1 reset mode=%0d status=%0h expected mode=0 status=80", readMode, statusByte);
    end
    curReq = "R2";
    wr(0, 16'hA570); idle(1);
    wr(0, 16'h3390); idle(1);
    wr(0, 16'h00FF); idle(1);
    wr(0, 16'h1270);
    curReq = "R10";
    wr(0, 16'h0000); idle(1);
    wr(0, 16'h00B0); wr(0, 16'h00D0); idle(1);
    curReq = "R3";
    wr(0, 16'h0040); wr(17'h1ABCD, 16'hEE5A);
    curReq = "R7";
    wr(0, 16'h00FF); wr(0, 16'h0090); wr(0, 16'h0020); wr(0, 16'h00B0);
    curReq = "R6";
    idle(6);
    curReq = "R3";
    wr(0, 16'h0010); wr(17'h00042, 16'h77C3);
    curReq = "R6";
    idle(PGM_N - 2);
    wr(0, 16'h0040);
    wr(17'h00100, 16'h0011);
    idle(PGM_N + 2);
    curReq = "R4";
    wr(0, 16'h0020); wr(17'h18000, 16'h00D0);
    curReq = "R7";
    wr(0, 16'h0050); wr(0, 16'h0040); wr(0, 16'h00FF);
    curReq = "R6";
    idle(ERS_N);
    curReq = "R5";
    wr(0, 16'h0020); wr(0, 16'h0033); idle(1);
    curReq = "R10";
    wr(0, 16'h0000); idle(1);
    curReq = "R9";
    wr(0, 16'h0050); idle(1);
    curReq = "R5";
    wr(0, 16'h0020); wr(0, 16'hD0FF); idle(1);
    curReq = "R8";
    wr(0, 16'h0020); wr(17'h04000, 16'h00D0);
    idle(3);
    wr(0, 16'h00B0);
    idle(5);
    wr(0, 16'h0070); wr(0, 16'h00FF);
    curReq = "R9";
    wr(0, 16'h0050); idle(1);
    curReq = "R8";
    wr(0, 16'h00D0);
    idle(ERS_N + 2);
    curReq = "R2";
    wr(0, 16'hFF90); idle(2);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule